// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps every in-flight instruction in a circular list of slots, from the cycle it is issued until the cycle it retires. A slot is claimed at the tail when an instruction issues, which needs a free reservation station and a free slot in the same cycle. Results come back from the common result bus in any order and are stored in their slots. The slot at the head retires as soon as its result is present, so register and memory state change only in program order.

Until a result retires, it stays speculative and lives only in its slot. When a later instruction issues, the block looks up each of its source registers in a rename table. The table holds a busy flag and the tag of the slot that will write the register. From that lookup the block returns the operand as a value taken from the register file, from a finished slot, or from a result on the bus in the same cycle. If none of these has the value yet, it returns the tag to wait for.

When a branch reaches the head with its mispredicted flag set, the block raises a flush for one cycle. In that same cycle it discards every slot and clears all rename state.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty: `commit_valid` and `flush` are 0, `issue_ready` follows `rs_free`, and every source register reads as ready with the register-file value.
- R2: An instruction is accepted only when `issue_valid`, `rs_free` and a free slot are all present. Accepted instructions get tags 0, 1, 2 and so on, wrapping modulo DEPTH.
- R3: After DEPTH accepted instructions with no retirement, `issue_ready` is 0 even with `rs_free` high, and nothing is accepted.
- R4: A source register that is not busy reads as ready, with the value on `rf_val_a`/`rf_val_b`.
- R5: A source register whose newest writer has no result yet reads as not ready, with that writer's tag on `opnd_*_tag`.
- R6: A source register whose newest writer has finished reads as ready with that writer's stored result. A bus write to that writer in the same cycle is forwarded as the value.
- R7: A bus write marks its slot finished. Slots retire one per cycle, in program order, and only when the head slot has finished; later slots that finish early wait.
- R8: A retirement shows the slot's tag, its kind (2'b00 register operation, 2'b01 store, 2'b10 branch), its register number, its stored value and, for a store, the address taken from the bus.
- R9: When a register operation retires, its register's busy flag clears only if the rename table still names that slot; a younger writer's rename stays in place.
- R10: A branch that retires with its mispredicted flag set raises `flush` in its retirement cycle. On the next edge every slot is freed, every register reads not busy, and the next tag is 0. `issue_ready` is 0 during the flush cycle. A branch without the flag retires with `flush` at 0.
- R11: A bus write naming a slot that holds no instruction has no effect; a later instruction placed in that slot still reads as not finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is offered for issue |
| rs_free | input | 1 | A reservation station is free |
| issue_kind | input | 2 | Kind: 00 register op, 01 store, 10 branch |
| issue_dest | input | REG_W | Destination register of a register op |
| issue_src_a | input | REG_W | First source register to look up |
| issue_src_b | input | REG_W | Second source register to look up |
| rf_val_a | input | XLEN | Register-file value of the first source |
| rf_val_b | input | XLEN | Register-file value of the second source |
| issue_ready | output | 1 | Issue is accepted this cycle if offered |
| issue_tag | output | TAG_W | Tag the offered instruction receives |
| opnd_a_ready | output | 1 | First operand value is available |
| opnd_a_value | output | XLEN | First operand value |
| opnd_a_tag | output | TAG_W | Slot to wait for when not ready |
| opnd_b_ready | output | 1 | Second operand value is available |
| opnd_b_value | output | XLEN | Second operand value |
| opnd_b_tag | output | TAG_W | Slot to wait for when not ready |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Slot the result belongs to |
| cdb_value | input | XLEN | Result value (store data for a store) |
| cdb_addr | input | XLEN | Memory address for a store |
| cdb_mispredict | input | 1 | Branch outcome differs from prediction |
| commit_valid | output | 1 | Head slot retires this cycle |
| commit_tag | output | TAG_W | Tag of the retiring slot |
| commit_kind | output | 2 | Kind of the retiring slot |
| commit_reg | output | REG_W | Destination register of the retiring slot |
| commit_addr | output | XLEN | Store address of the retiring slot |
| commit_value | output | XLEN | Result of the retiring slot |
| flush | output | 1 | Misprediction at the head; all state is discarded |

## Verification
The bench builds the block with DEPTH=4, NREG=8 and XLEN=32. With only four slots, the full condition, the wrap of the tag back to 0 after a flush, and reuse of a freed slot all come up within a few dozen cycles. With eight registers, one register can be written by an older and a younger instruction at the same time. That case shows the younger rename surviving the older retirement. It also lets a finished, unretired slot be read while an older slot still holds the head.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } rob_kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             retire,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic             full,
  output logic             empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;

  // circular advance, valid for any depth
  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    if (p == TAG_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc)  tail <= bump(tail);
      if (retire) head <= bump(head);
      unique case ({alloc, retire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full);
  p_count_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> !empty);
  p_flush_resets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && head == '0 && tail == '0));
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
  parameter int DEPTH = 8,
  parameter int XLEN  = 32,
  parameter int REG_W = 5,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic [1:0]       alloc_kind,
  input  logic [REG_W-1:0] alloc_reg,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic [XLEN-1:0]  wb_value,
  input  logic [XLEN-1:0]  wb_addr,
  input  logic             wb_misp,
  input  logic             retire,
  input  logic [TAG_W-1:0] head_tag,
  input  logic [TAG_W-1:0] rd_a_tag,
  input  logic [TAG_W-1:0] rd_b_tag,
  output logic             head_valid,
  output logic             head_ready,
  output logic [1:0]       head_kind,
  output logic [REG_W-1:0] head_reg,
  output logic [XLEN-1:0]  head_value,
  output logic [XLEN-1:0]  head_addr,
  output logic             head_misp,
  output logic             rd_a_ready,
  output logic [XLEN-1:0]  rd_a_value,
  output logic             rd_b_ready,
  output logic [XLEN-1:0]  rd_b_value,
  output logic             wb_hit
);
  logic [DEPTH-1:0] valid_q, ready_q, misp_q;
  logic [1:0]       kind_q [DEPTH];
  logic [REG_W-1:0] reg_q  [DEPTH];
  logic [XLEN-1:0]  val_q  [DEPTH];
  logic [XLEN-1:0]  addr_q [DEPTH];

  // a result lands only in a slot that holds an instruction
  assign wb_hit = wb_valid && valid_q[wb_tag];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q <= '0;
      ready_q <= '0;
      misp_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc && alloc_tag == TAG_W'(i)) begin
          valid_q[i] <= 1'b1;
          ready_q[i] <= 1'b0;
          misp_q[i]  <= 1'b0;
        end else begin
          if (retire && head_tag == TAG_W'(i)) begin
            valid_q[i] <= 1'b0;
            ready_q[i] <= 1'b0;
          end
          if (wb_hit && wb_tag == TAG_W'(i)) begin
            ready_q[i] <= 1'b1;
            misp_q[i]  <= wb_misp;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc && alloc_tag == TAG_W'(i)) begin
        kind_q[i] <= alloc_kind;
        reg_q[i]  <= alloc_reg;
      end
      if (wb_hit && wb_tag == TAG_W'(i)) begin
        val_q[i]  <= wb_value;
        addr_q[i] <= wb_addr;
      end
    end
  end

  assign head_valid = valid_q[head_tag];
  assign head_ready = ready_q[head_tag];
  assign head_kind  = kind_q[head_tag];
  assign head_reg   = reg_q[head_tag];
  assign head_value = val_q[head_tag];
  assign head_addr  = addr_q[head_tag];
  assign head_misp  = misp_q[head_tag];

  assign rd_a_ready = ready_q[rd_a_tag];
  assign rd_a_value = val_q[rd_a_tag];
  assign rd_b_ready = ready_q[rd_b_tag];
  assign rd_b_value = val_q[rd_b_tag];

  p_alloc_free_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !valid_q[alloc_tag]);
  p_single_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_hit |-> !ready_q[wb_tag]);
  p_stray_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !valid_q[wb_tag] && !(alloc && alloc_tag == wb_tag))
      |=> !ready_q[$past(wb_tag)]);
endmodule

// File: rtl/rob_rename_table.sv
module rob_rename_table #(
  parameter int NREG  = 32,
  parameter int TAG_W = 3,
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg,
  input  logic [TAG_W-1:0] clr_tag,
  input  logic [REG_W-1:0] look_a,
  input  logic [REG_W-1:0] look_b,
  output logic             a_busy,
  output logic [TAG_W-1:0] a_tag,
  output logic             b_busy,
  output logic [TAG_W-1:0] b_tag
);
  logic [NREG-1:0]  busy_vec;
  logic [TAG_W-1:0] tag_vec [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic             busy_q;
    logic [TAG_W-1:0] tag_q;
    logic             set_hit, clr_hit;

    assign set_hit = set_en && set_reg == REG_W'(r);
    // only the owning writer may release the rename
    assign clr_hit = clr_en && clr_reg == REG_W'(r) && tag_q == clr_tag;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        tag_q  <= '0;
      end else if (flush) begin
        busy_q <= 1'b0;
      end else if (set_hit) begin
        busy_q <= 1'b1;
        tag_q  <= set_tag;
      end else if (clr_hit) begin
        busy_q <= 1'b0;
      end
    end

    assign busy_vec[r] = busy_q;
    assign tag_vec[r]  = tag_q;

    p_younger_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && clr_reg == REG_W'(r) && busy_q && tag_q != clr_tag && !flush)
        |=> busy_q);
  end

  assign a_busy = busy_vec[look_a];
  assign a_tag  = tag_vec[look_a];
  assign b_busy = busy_vec[look_b];
  assign b_tag  = tag_vec[look_b];

  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy_vec == '0));
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer #(
  parameter int DEPTH = 8,
  parameter int NREG  = 32,
  parameter int XLEN  = 32,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic             rs_free,
  input  logic [1:0]       issue_kind,
  input  logic [REG_W-1:0] issue_dest,
  input  logic [REG_W-1:0] issue_src_a,
  input  logic [REG_W-1:0] issue_src_b,
  input  logic [XLEN-1:0]  rf_val_a,
  input  logic [XLEN-1:0]  rf_val_b,
  output logic             issue_ready,
  output logic [TAG_W-1:0] issue_tag,
  output logic             opnd_a_ready,
  output logic [XLEN-1:0]  opnd_a_value,
  output logic [TAG_W-1:0] opnd_a_tag,
  output logic             opnd_b_ready,
  output logic [XLEN-1:0]  opnd_b_value,
  output logic [TAG_W-1:0] opnd_b_tag,
  input  logic             cdb_valid,
  input  logic [TAG_W-1:0] cdb_tag,
  input  logic [XLEN-1:0]  cdb_value,
  input  logic [XLEN-1:0]  cdb_addr,
  input  logic             cdb_mispredict,
  output logic             commit_valid,
  output logic [TAG_W-1:0] commit_tag,
  output logic [1:0]       commit_kind,
  output logic [REG_W-1:0] commit_reg,
  output logic [XLEN-1:0]  commit_addr,
  output logic [XLEN-1:0]  commit_value,
  output logic             flush
);
  import rob_pkg::*;

  logic             full, empty;
  logic [TAG_W-1:0] head, tail;
  logic             alloc_fire, commit_fire, flush_fire;
  logic             head_valid, head_ready, head_misp;
  logic [1:0]       head_kind;
  logic [REG_W-1:0] head_reg;
  logic [XLEN-1:0]  head_value, head_addr;
  logic             a_busy, b_busy;
  logic [TAG_W-1:0] a_tag, b_tag;
  logic             ent_a_ready, ent_b_ready;
  logic [XLEN-1:0]  ent_a_value, ent_b_value;
  logic             wb_hit;

  // operand source choice: register file, finished slot, or bus this cycle
  function automatic logic [XLEN:0] pick_operand(
    input logic            busy,
    input logic            ent_ready,
    input logic [XLEN-1:0] ent_value,
    input logic            bus_match,
    input logic [XLEN-1:0] bus_value,
    input logic [XLEN-1:0] rf_value);
    if (!busy)     return {1'b1, rf_value};
    if (ent_ready) return {1'b1, ent_value};
    if (bus_match) return {1'b1, bus_value};
    return {1'b0, {XLEN{1'b0}}};
  endfunction

  assign commit_fire = head_valid && head_ready;
  assign flush_fire  = commit_fire && head_kind == KIND_BRANCH && head_misp;
  assign issue_ready = rs_free && !full && !flush_fire;
  assign alloc_fire  = issue_valid && issue_ready;
  assign issue_tag   = tail;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .alloc  (alloc_fire),
    .retire (commit_fire),
    .flush  (flush_fire),
    .head   (head),
    .tail   (tail),
    .full   (full),
    .empty  (empty)
  );

  rob_entry_store #(.DEPTH(DEPTH), .XLEN(XLEN), .REG_W(REG_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_fire),
    .alloc      (alloc_fire),
    .alloc_tag  (tail),
    .alloc_kind (issue_kind),
    .alloc_reg  (issue_dest),
    .wb_valid   (cdb_valid),
    .wb_tag     (cdb_tag),
    .wb_value   (cdb_value),
    .wb_addr    (cdb_addr),
    .wb_misp    (cdb_mispredict),
    .retire     (commit_fire),
    .head_tag   (head),
    .rd_a_tag   (a_tag),
    .rd_b_tag   (b_tag),
    .head_valid (head_valid),
    .head_ready (head_ready),
    .head_kind  (head_kind),
    .head_reg   (head_reg),
    .head_value (head_value),
    .head_addr  (head_addr),
    .head_misp  (head_misp),
    .rd_a_ready (ent_a_ready),
    .rd_a_value (ent_a_value),
    .rd_b_ready (ent_b_ready),
    .rd_b_value (ent_b_value),
    .wb_hit     (wb_hit)
  );

  rob_rename_table #(.NREG(NREG), .TAG_W(TAG_W)) u_rename (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush_fire),
    .set_en  (alloc_fire && issue_kind == KIND_REG),
    .set_reg (issue_dest),
    .set_tag (tail),
    .clr_en  (commit_fire && head_kind == KIND_REG),
    .clr_reg (head_reg),
    .clr_tag (head),
    .look_a  (issue_src_a),
    .look_b  (issue_src_b),
    .a_busy  (a_busy),
    .a_tag   (a_tag),
    .b_busy  (b_busy),
    .b_tag   (b_tag)
  );

  assign {opnd_a_ready, opnd_a_value} = pick_operand(a_busy, ent_a_ready, ent_a_value,
    wb_hit && cdb_tag == a_tag, cdb_value, rf_val_a);
  assign {opnd_b_ready, opnd_b_value} = pick_operand(b_busy, ent_b_ready, ent_b_value,
    wb_hit && cdb_tag == b_tag, cdb_value, rf_val_b);
  assign opnd_a_tag = a_tag;
  assign opnd_b_tag = b_tag;

  assign commit_valid = commit_fire;
  assign commit_tag   = head;
  assign commit_kind  = head_kind;
  assign commit_reg   = head_reg;
  assign commit_addr  = head_addr;
  assign commit_value = head_value;
  assign flush        = flush_fire;

  p_flush_blocks_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !issue_ready);
  p_issue_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready) |=> !empty);
  p_retire_advances_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !flush) |=> (commit_tag != $past(commit_tag) || !commit_valid));
  p_busy_has_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_a_ready == 1'b0 |-> (a_busy && !empty));
endmodule

// File: tb/test_reorder_buffer.sv
module test_reorder_buffer;
  localparam int DEPTH = 4;
  localparam int NREG  = 8;
  localparam int XLEN  = 32;
  localparam int TAG_W = 2;
  localparam int REG_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             issue_valid = 1'b0, rs_free = 1'b1;
  logic [1:0]       issue_kind = 2'b00;
  logic [REG_W-1:0] issue_dest = '0, issue_src_a = '0, issue_src_b = '0;
  logic [XLEN-1:0]  rf_val_a = '0, rf_val_b = '0;
  logic             issue_ready;
  logic [TAG_W-1:0] issue_tag;
  logic             opnd_a_ready, opnd_b_ready;
  logic [XLEN-1:0]  opnd_a_value, opnd_b_value;
  logic [TAG_W-1:0] opnd_a_tag, opnd_b_tag;
  logic             cdb_valid = 1'b0, cdb_mispredict = 1'b0;
  logic [TAG_W-1:0] cdb_tag = '0;
  logic [XLEN-1:0]  cdb_value = '0, cdb_addr = '0;
  logic             commit_valid, flush;
  logic [TAG_W-1:0] commit_tag;
  logic [1:0]       commit_kind;
  logic [REG_W-1:0] commit_reg;
  logic [XLEN-1:0]  commit_addr, commit_value;

  reorder_buffer #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN)) i_reorder_buffer (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .rs_free(rs_free), .issue_kind(issue_kind),
    .issue_dest(issue_dest), .issue_src_a(issue_src_a), .issue_src_b(issue_src_b),
    .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
    .issue_ready(issue_ready), .issue_tag(issue_tag),
    .opnd_a_ready(opnd_a_ready), .opnd_a_value(opnd_a_value), .opnd_a_tag(opnd_a_tag),
    .opnd_b_ready(opnd_b_ready), .opnd_b_value(opnd_b_value), .opnd_b_tag(opnd_b_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .cdb_addr(cdb_addr), .cdb_mispredict(cdb_mispredict),
    .commit_valid(commit_valid), .commit_tag(commit_tag), .commit_kind(commit_kind),
    .commit_reg(commit_reg), .commit_addr(commit_addr), .commit_value(commit_value),
    .flush(flush)
  );

  always #5 clk = ~clk;

  typedef struct {
    int         tag;
    logic [1:0] kind;
    int         rg;
  } item_t;

  item_t       exp_q[$];
  logic [31:0] exp_val  [DEPTH];
  logic [31:0] exp_addr [DEPTH];
  logic        exp_misp [DEPTH];
  int          exp_tail = 0;
  int          total = 0, bad = 0, commits = 0;
  bit          done = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    issue_valid = 1'b0;
    cdb_valid = 1'b0;
    cdb_mispredict = 1'b0;
  endtask

  // driver: offers one instruction and queues its expected retirement
  task automatic issue(input logic [1:0] kind, input int dest, input int sa, input int sb);
    item_t it;
    issue_valid = 1'b1;
    issue_kind  = kind;
    issue_dest  = REG_W'(dest);
    issue_src_a = REG_W'(sa);
    issue_src_b = REG_W'(sb);
    rf_val_a    = 32'hA000_0000 | sa;
    rf_val_b    = 32'hB000_0000 | sb;
    #1;
    chk("R2", "issue_ready", issue_ready, 1);
    chk("R2", "issue_tag", issue_tag, exp_tail);
    it.tag = exp_tail; it.kind = kind; it.rg = dest;
    exp_q.push_back(it);
    exp_misp[exp_tail] = 1'b0;
    exp_tail = (exp_tail + 1) % DEPTH;
  endtask

  task automatic bus(input int tag, input logic [31:0] val, input logic [31:0] addr,
                     input logic misp, input bit record);
    cdb_valid = 1'b1;
    cdb_tag = TAG_W'(tag);
    cdb_value = val;
    cdb_addr = addr;
    cdb_mispredict = misp;
    if (record) begin
      exp_val[tag] = val;
      exp_addr[tag] = addr;
      exp_misp[tag] = misp;
    end
  endtask

  task automatic look(input int sa, input int sb);
    issue_src_a = REG_W'(sa);
    issue_src_b = REG_W'(sb);
    rf_val_a = 32'hA000_0000 | sa;
    rf_val_b = 32'hB000_0000 | sb;
    #1;
  endtask

  // monitor: pops the scoreboard on every retirement
  always @(negedge clk) begin
    if (rst_n && commit_valid) begin
      commits++;
      if (exp_q.size() == 0) begin
        chk("R7", "unexpected retirement", 1, 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk("R7", "retire order tag", commit_tag, it.tag);
        chk("R8", "retire kind", commit_kind, it.kind);
        if (it.kind == 2'b00) begin
          chk("R8", "retire reg", commit_reg, it.rg);
          chk("R8", "retire value", commit_value, exp_val[it.tag]);
        end
        if (it.kind == 2'b01) begin
          chk("R8", "store value", commit_value, exp_val[it.tag]);
          chk("R8", "store addr", commit_addr, exp_addr[it.tag]);
        end
        chk("R10", "flush on retire",
            flush, (it.kind == 2'b10) ? exp_misp[it.tag] : 1'b0);
        if (flush) begin
          exp_q.delete();
          exp_tail = 0;
        end
      end
    end else if (rst_n && flush) begin
      chk("R10", "flush without retirement", 1, 0);
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      chk("watchdog", "run hung", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    look(3, 6);
    chk("R1", "commit_valid", commit_valid, 0);
    chk("R1", "flush", flush, 0);
    chk("R1", "issue_ready", issue_ready, 1);
    chk("R1", "opnd a ready", opnd_a_ready, 1);
    chk("R1", "opnd a value", opnd_a_value, 32'hA000_0003);
    chk("R1", "opnd b value", opnd_b_value, 32'hB000_0006);

    // R2: no reservation station, no issue
    rs_free = 1'b0; issue_valid = 1'b1; #1;
    chk("R2", "ready without station", issue_ready, 0);
    tick(); rs_free = 1'b1;

    issue(2'b00, 1, 2, 3);                       // tag0: r1
    chk("R4", "free reg a ready", opnd_a_ready, 1);
    chk("R4", "free reg a value", opnd_a_value, 32'hA000_0002);
    chk("R4", "free reg b value", opnd_b_value, 32'hB000_0003);
    tick();
    issue(2'b00, 4, 1, 2);                       // tag1: r4 <- r1
    chk("R5", "pending a ready", opnd_a_ready, 0);
    chk("R5", "pending a tag", opnd_a_tag, 0);
    chk("R4", "free b ready", opnd_b_ready, 1);
    tick();
    issue(2'b01, 0, 4, 3);                       // tag2: store
    chk("R5", "pending store src tag", opnd_a_tag, 1);
    chk("R5", "pending store src ready", opnd_a_ready, 0);
    tick();
    issue(2'b00, 1, 5, 6);                       // tag3: younger r1 writer
    tick();
    issue_valid = 1'b1; #1;
    chk("R3", "ready when full", issue_ready, 0);
    tick();

    bus(2, 32'h2222, 32'h80, 1'b0, 1'b1);        // finish out of order
    tick();
    chk("R7", "later slot waits", commit_valid, 0);
    bus(3, 32'h3333, 32'h0, 1'b0, 1'b1);
    tick();
    chk("R7", "head still open", commit_valid, 0);
    bus(0, 32'h1111, 32'h0, 1'b0, 1'b1);
    tick();                                       // tag0 retires at next edge
    tick();

    // tag0 (r1) retired; r1 still owned by finished tag3; r4 forwarded from bus
    bus(1, 32'h4444, 32'h0, 1'b0, 1'b1);
    issue(2'b00, 5, 1, 4);                       // tag0 again
    chk("R9", "younger rename kept", opnd_a_ready, 1);
    chk("R6", "finished slot value", opnd_a_value, 32'h3333);
    chk("R6", "bus forward ready", opnd_b_ready, 1);
    chk("R6", "bus forward value", opnd_b_value, 32'h4444);
    tick();
    tick(); tick(); tick();                      // tags 1,2,3 retire
    look(1, 4);
    chk("R9", "owner retired r1 free", opnd_a_value, 32'hA000_0001);
    chk("R9", "owner retired r4 free", opnd_b_value, 32'hB000_0004);

    bus(2, 32'hDEAD, 32'h0, 1'b0, 1'b0);         // slot 2 empty
    tick();
    issue(2'b10, 0, 0, 0);                       // tag1 branch
    tick();
    issue(2'b00, 7, 0, 0);                       // tag2 r7
    tick();
    issue(2'b00, 2, 7, 5);                       // tag3 r2 <- r7, r5
    chk("R11", "stray write ignored", opnd_a_ready, 0);
    chk("R11", "waits on slot 2", opnd_a_tag, 2);
    chk("R5", "r5 waits on tag0", opnd_b_tag, 0);
    tick();

    bus(1, 32'h0, 32'h0, 1'b1, 1'b1);            // mispredicted branch
    tick();
    bus(0, 32'h5555, 32'h0, 1'b0, 1'b1);
    tick();
    tick();                                       // tag0 retired, branch at head
    chk("R10", "flush raised", flush, 1);
    chk("R10", "no issue during flush", issue_ready, 0);
    tick();
    look(7, 2);
    chk("R10", "r7 cleared", opnd_a_ready, 1);
    chk("R10", "r2 cleared value", opnd_b_value, 32'hB000_0002);
    chk("R10", "empty after flush", issue_ready, 1);
    chk("R10", "no retire after flush", commit_valid, 0);
    issue(2'b10, 0, 0, 0);                       // tag restarts at 0
    tick();
    bus(0, 32'h0, 32'h0, 1'b0, 1'b1);            // correctly predicted
    tick();
    tick();
    tick();
    chk("R7", "scoreboard drained", exp_q.size(), 0);
    chk("R7", "retirement count", commits, 7);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule